// File: doc/BRIEF.md
# Stereo Sample DMA Playback Engine

This block plays packed 8-bit stereo audio out of memory. Each 16-bit memory word holds one left sample in its upper byte and one right sample in its lower byte. A free-running divider makes one output slot per word at one of four rates. Between slots the engine asks the memory side for the next word and holds it in a one-word buffer. At each slot it sends the buffered word out as two bytes, one after the other, on a shared 8-bit bus. A strobe goes with each byte so that an external left or right converter latch can capture it.

Playback runs from a start word address up to, but not including, an end word address. When the last word is fetched, the engine pulls an active-low end-of-sample interrupt low for a fixed number of cycles. It then either restarts from the start address (loop mode) or stops once the last word has been played. A delay stage derives a timer input from the interrupt. It is a shift chain stepped by a 2 MHz enable, and it is held clear whenever the interrupt is inactive. Its output therefore rises only if the interrupt stays low for eight of those ticks.

Top module: `sdma_play`

## Requirements
- R1: An output slot occurs every `BASE_DIV << (3 - rate_sel)` clock cycles while playing. With the default `BASE_DIV` of 160 on an 8 MHz sample clock, this gives 1280, 640, 320 and 160 cycles for `rate_sel` 0, 1, 2 and 3.
- R2: `mem_req` is high exactly while playing, with the word buffer empty and the fetch range not yet finished. A word is taken from `mem_data` on a clock edge where both `mem_req` and `mem_load` are high.
- R3: A rising edge of `play_en` starts playback at `start_addr`. The address on `mem_addr` then advances by one for each word taken. `end_addr` must be greater than `start_addr`.
- R4: At a slot with a buffered word, `snd_data` shows bits 15:8 with `left_stb` high for one cycle. In the next cycle, `snd_data` shows bits 7:0 with `right_stb` high for one cycle.
- R5: When a word is taken from address `end_addr - 1`, `sint_n` goes low in the next cycle and stays low for `INT_LEN` cycles.
- R6: After taking the word at `end_addr - 1`, the engine behaves according to `loop_en`. If `loop_en` is set, the address reloads from `start_addr` and playback continues. If it is clear, fetching stops, and `playing` drops at the first slot that finds the buffer empty.
- R7: `timer_out` rises once `sint_n` has been low for 8 × `PRE_DIV` consecutive cycles (32 cycles by default, 4 µs at 8 MHz). It returns low one cycle after `sint_n` goes high.
- R8: If `sint_n` is low for fewer than 8 × `PRE_DIV` cycles, `timer_out` does not rise.
- R9: At a slot where the buffer is empty and the fetch range is not finished, no strobe is issued, `snd_data` keeps its value, and `underrun` is set. `underrun` stays set until the next start.
- R10: After reset, `playing`, `mem_req`, both strobes, `timer_out`, `underrun` and `snd_data` are 0, and `sint_n` is 1.
- R11: When `play_en` is low, `playing` is 0 from the next cycle and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (about 8 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Playback enable; a rising edge starts playback |
| loop_en | input | 1 | Reload from the start address at the end of the range |
| rate_sel | input | 2 | Word-rate select |
| start_addr | input | AW | First word address |
| end_addr | input | AW | Address one past the last word |
| mem_req | output | 1 | Request for the next word |
| mem_addr | output | AW | Address of the requested word |
| mem_load | input | 1 | Memory side signals that `mem_data` is valid |
| mem_data | input | 16 | Fetched word: left byte high, right byte low |
| snd_data | output | 8 | Shared byte bus to the converter latches |
| left_stb | output | 1 | Left latch strobe |
| right_stb | output | 1 | Right latch strobe |
| sint_n | output | 1 | Active-low end-of-sample interrupt |
| timer_out | output | 1 | Delayed interrupt sent to a timer input |
| playing | output | 1 | Playback active |
| underrun | output | 1 | A slot found no word ready |

## Verification
Some properties are checked by assertions on every cycle. The two strobes are never high together, and a left strobe is always followed by a right strobe. A fall of `sint_n` is always preceded by an accepted fetch. A rise of `timer_out` only happens while the interrupt is low. `underrun` stays set until a restart, and `playing` stays low while playback is disabled. Other behaviour can only be shown by the bench's scenarios and its per-cycle reference model. This covers the exact slot spacing at each rate, the order of the addresses fetched, the number of words played before a stop, the byte values sent, the timing of the 32-cycle delay, and a short interrupt that never reaches the timer.

// File: rtl/sdma_play.sv
module sdma_play #(
  parameter int AW       = 16,
  parameter int BASE_DIV = 160,
  parameter int INT_LEN  = 64,
  parameter int PRE_DIV  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play_en,
  input  logic          loop_en,
  input  logic [1:0]    rate_sel,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_load,
  input  logic [15:0]   mem_data,
  output logic [7:0]    snd_data,
  output logic          left_stb,
  output logic          right_stb,
  output logic          sint_n,
  output logic          timer_out,
  output logic          playing,
  output logic          underrun
);
  localparam int DW = $clog2(BASE_DIV * 8) + 1;
  localparam int IW = $clog2(INT_LEN + 1) + 1;
  localparam int PW = $clog2(PRE_DIV) + 1;

  logic          en_q, buf_ok, fetch_done;
  logic [AW-1:0] cur;
  logic [15:0]   wbuf;
  logic [7:0]    lo_hold, dly;
  logic [DW-1:0] div, period;
  logic [IW-1:0] int_cnt;
  logic [PW-1:0] pre;

  wire start   = play_en & ~en_q;
  wire go      = playing & play_en & ~start;
  wire slot    = go & (div == period - 1'b1);
  wire take    = go & mem_req & mem_load;
  wire last    = (cur + 1'b1) == end_addr;
  wire pre_hit = pre == PW'(PRE_DIV - 1);

  assign period    = DW'(BASE_DIV) << (2'd3 - rate_sel);
  assign mem_req   = playing & ~buf_ok & ~fetch_done;
  assign mem_addr  = cur;
  assign sint_n    = (int_cnt == '0);
  assign timer_out = dly[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; playing <= 1'b0; cur <= '0; wbuf <= '0; buf_ok <= 1'b0;
      fetch_done <= 1'b0; underrun <= 1'b0; div <= '0;
    end else begin
      en_q <= play_en;
      if (start) begin
        playing <= 1'b1; cur <= start_addr; buf_ok <= 1'b0;
        fetch_done <= 1'b0; underrun <= 1'b0; div <= '0;
      end else if (!play_en) begin
        playing <= 1'b0; buf_ok <= 1'b0; div <= '0;
      end else if (playing) begin
        div <= slot ? '0 : div + 1'b1;
        if (take) begin
          wbuf   <= mem_data;
          buf_ok <= 1'b1;
          if (last && loop_en) cur <= start_addr;
          else cur <= cur + 1'b1;
          if (last && !loop_en) fetch_done <= 1'b1;
        end
        if (slot) begin
          if (buf_ok) buf_ok <= 1'b0;
          else if (fetch_done) playing <= 1'b0;
          else underrun <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_data <= '0; lo_hold <= '0; left_stb <= 1'b0; right_stb <= 1'b0;
    end else begin
      left_stb  <= 1'b0;
      right_stb <= 1'b0;
      if (slot && buf_ok) begin
        snd_data <= wbuf[15:8]; lo_hold <= wbuf[7:0]; left_stb <= 1'b1;
      end else if (left_stb) begin
        snd_data <= lo_hold; right_stb <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_cnt <= '0;
    else if (take && last) int_cnt <= IW'(INT_LEN);
    else if (int_cnt != '0) int_cnt <= int_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; dly <= '0;
    end else if (sint_n) begin
      pre <= '0; dly <= '0;
    end else begin
      pre <= pre_hit ? '0 : pre + 1'b1;
      if (pre_hit) dly <= {dly[6:0], 1'b1};
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_stb && right_stb));
  assert_right_after_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    left_stb |=> right_stb);
  assert_int_from_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sint_n) |-> $past(mem_req && mem_load));
  assert_timer_needs_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_out) |-> !sint_n && $past(!sint_n));
  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !start |=> underrun);
  assert_disable_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> !playing && !mem_req);
endmodule

// File: tb/sdma_play_tb_top.sv
module sdma_play_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic play_en = 0, loop_en = 0, mem_load = 0;
  logic [1:0] rate_sel = 3;
  logic [15:0] start_addr = 0, end_addr = 0, mem_data = 0;
  logic mem_req, left_stb, right_stb, sint_n, timer_out, playing, underrun;
  logic [15:0] mem_addr;
  logic [7:0] snd_data;
  logic s_req, s_l, s_r, s_sint, s_timer, s_play, s_under;
  logic [15:0] s_addr;
  logic [7:0] s_data;

  sdma_play dut_i (.clk, .rst_n, .play_en, .loop_en, .rate_sel, .start_addr, .end_addr,
    .mem_req, .mem_addr, .mem_load, .mem_data, .snd_data, .left_stb, .right_stb,
    .sint_n, .timer_out, .playing, .underrun);
  sdma_play #(.INT_LEN(16)) dut_s (.clk, .rst_n, .play_en, .loop_en, .rate_sel,
    .start_addr, .end_addr, .mem_req(s_req), .mem_addr(s_addr), .mem_load, .mem_data,
    .snd_data(s_data), .left_stb(s_l), .right_stb(s_r), .sint_n(s_sint),
    .timer_out(s_timer), .playing(s_play), .underrun(s_under));

  int checks = 0, fails = 0, cyc = 0, lcount = 0, trises = 0, last_l = 0, gap = 0;
  int s_low_seen = 0, lc = 0;
  bit stall = 0, model_on = 0;

  // behavioural reference model
  int m_play, m_cur, m_buf, m_bv, m_done, m_div, m_data, m_l, m_r, m_hold;
  int m_int, m_under, m_low, m_enq, m_tprev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int m_req();
    return (m_play && !m_bv && !m_done) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_play = 0; m_cur = 0; m_buf = 0; m_bv = 0; m_done = 0; m_div = 0; m_data = 0;
      m_l = 0; m_r = 0; m_hold = 0; m_int = 0; m_under = 0; m_low = 0; m_enq = 0;
    end else begin
      automatic int per = 160 << (3 - rate_sel);
      automatic int st = (play_en && !m_enq) ? 1 : 0;
      automatic int go = (m_play && play_en && !st) ? 1 : 0;
      automatic int sl = (go && m_div == per - 1) ? 1 : 0;
      automatic int tk = (go && m_req() && mem_load) ? 1 : 0;
      automatic int ls = (((m_cur + 1) % 65536) == end_addr) ? 1 : 0;
      automatic int nl = 0, nr = 0;
      // interrupt and delay use pre-edge interrupt level
      if (m_int == 0) m_low = 0; else m_low++;
      if (tk && ls) m_int = 64; else if (m_int > 0) m_int--;
      // byte sequencing
      if (sl && m_bv) begin m_data = m_buf >> 8; m_hold = m_buf & 255; nl = 1; end
      else if (m_l) begin m_data = m_hold; nr = 1; end
      m_l = nl; m_r = nr;
      if (st) begin
        m_play = 1; m_cur = start_addr; m_bv = 0; m_done = 0; m_under = 0; m_div = 0;
      end else if (!play_en) begin
        m_play = 0; m_bv = 0; m_div = 0;
      end else if (m_play) begin
        automatic int was_bv = m_bv;
        m_div = sl ? 0 : m_div + 1;
        if (tk) begin
          m_buf = mem_data; m_bv = 1;
          if (ls && loop_en) m_cur = start_addr; else m_cur = (m_cur + 1) % 65536;
          if (ls && !loop_en) m_done = 1;
        end
        if (sl) begin
          if (was_bv) m_bv = 0;
          else if (m_done) m_play = 0;
          else m_under = 1;
        end
      end
      m_enq = play_en;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (model_on) begin
      chk(mem_req == m_req(), "R2 mem_req", mem_req, m_req());
      if (mem_req) chk(mem_addr == m_cur, "R3 mem_addr", mem_addr, m_cur);
      chk(left_stb == m_l, "R4 left_stb", left_stb, m_l);
      chk(right_stb == m_r, "R4 right_stb", right_stb, m_r);
      chk(snd_data == m_data, "R4 snd_data", snd_data, m_data);
      chk(sint_n == (m_int == 0), "R5 sint_n", sint_n, m_int == 0);
      chk(timer_out == (m_low >= 32), "R7 timer_out", timer_out, m_low >= 32);
      chk(playing == m_play, "R6 playing", playing, m_play);
      chk(underrun == m_under, "R9 underrun", underrun, m_under);
      chk(s_timer == 0, "R8 short-pulse timer", s_timer, 0);
    end
    if (left_stb) begin lcount++; gap = cyc - last_l; last_l = cyc; end
    if (timer_out && !m_tprev) trises++;
    m_tprev = timer_out;
    if (!s_sint) s_low_seen = 1;
    if (!mem_req || stall) begin lc = 0; mem_load = 0; end
    else begin lc++; mem_load = (lc >= 3); end
    mem_data = {mem_addr[7:0] ^ 8'h5A, mem_addr[7:0]};
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    // R10 reset state
    chk(!playing && !mem_req && !left_stb && !right_stb && !timer_out && !underrun
        && snd_data == 0 && sint_n, "R10 reset state",
        {playing, mem_req, left_stb, right_stb, timer_out, underrun, sint_n}, 1);
    rst_n = 1; model_on = 1;
    wait_cyc(2);

    // one-shot run, fastest rate
    rate_sel = 3; loop_en = 0; start_addr = 16'h100; end_addr = 16'h106;
    lcount = 0; trises = 0;
    play_en = 1;
    wait_cyc(2);
    while (playing) @(negedge clk);
    chk(lcount == 6, "R6 one-shot word count", lcount, 6);
    chk(trises == 1, "R7 timer rose once", trises, 1);
    chk(gap == 160, "R1 slot spacing rate 3", gap, 160);
    chk(s_low_seen == 1, "R8 short interrupt seen", s_low_seen, 1);
    play_en = 0;
    wait_cyc(4);
    chk(!playing && !mem_req, "R11 disabled", playing, 0);

    // loop run with underrun
    rate_sel = 2; loop_en = 1; start_addr = 16'h20; end_addr = 16'h23;
    play_en = 1;
    wait_cyc(3000);
    chk(playing == 1, "R6 loop keeps playing", playing, 1);
    chk(gap == 320, "R1 slot spacing rate 2", gap, 320);
    stall = 1;
    wait_cyc(400);
    begin
      automatic int lc0 = lcount;
      automatic logic [7:0] snap = snd_data;
      wait_cyc(330);
      chk(lcount == lc0, "R9 no strobe on underrun", lcount, lc0);
      chk(snd_data == snap, "R9 data held", snd_data, snap);
    end
    chk(underrun == 1, "R9 underrun set", underrun, 1);
    stall = 0;
    wait_cyc(1500);
    chk(underrun == 1, "R9 underrun sticky", underrun, 1);
    play_en = 0;
    wait_cyc(2);
    chk(!playing && !mem_req, "R11 stop on disable", playing, 0);

    // slow rates
    rate_sel = 0; loop_en = 1; start_addr = 16'h40; end_addr = 16'h48;
    play_en = 1;
    wait_cyc(4000);
    chk(gap == 1280, "R1 slot spacing rate 0", gap, 1280);
    chk(underrun == 0, "R3 restart clears underrun", underrun, 0);
    rate_sel = 1;
    wait_cyc(2000);
    chk(gap == 640, "R1 slot spacing rate 1", gap, 640);
    play_en = 0;
    wait_cyc(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule